// File: doc/BRIEF.md
# I2C SCL Timing Generator

This block times the SCL clock of an I2C master from the peripheral clock. It alternates between a phase in which SCL is pulled low and a phase in which SCL is released, and it signals each change to the byte engine with a one-cycle strobe. The length of each phase comes from a 12-bit divider value, a standard/fast mode select and, in fast mode, a duty select that picks between a 2:1 and a 16:9 low-to-high ratio.

The released phase is not a blind count. After SCL is released the generator waits until it samples SCL high, so a slow rising edge does not eat into the high time. The wait is capped by a programmed rise allowance. Once the high count has started it runs to completion. Divider values under the legal minimum of each mode are raised to that minimum. While the enable input is low the generator sits idle with SCL released.

Each phase length is captured into a down counter when the phase begins. A change to the divider or mode while a phase is running therefore first takes effect at the next phase. The SCL input is assumed to be already synchronised to the peripheral clock.

Top module: `scl_timing_gen`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `enable` low, `scl_drive_low`, `low_strobe` and `release_strobe` are all 0.
- R2: With `fast_sel` = 0 (standard mode), the low phase and the high count both last C cycles, where C is `ccr_val`. `duty_sel` has no effect in this mode.
- R3: With `fast_sel` = 1 and `duty_sel` = 0, the low phase lasts 2×C cycles and the high count lasts C cycles.
- R4: With `fast_sel` = 1 and `duty_sel` = 1, the low phase lasts 16×C cycles and the high count lasts 9×C cycles.
- R5: C is `ccr_val` raised to a floor. The floor is 4 in standard mode and 1 in fast mode.
- R6: Let the first clock edge after release that samples `scl_in` high be edge d, counting from 1. If d is at most the rise allowance A, then `scl_drive_low` stays 0 for d + H − 1 cycles, where H is the high count.
- R7: A is `rise_lim`, and a value of 0 acts as 1. If `scl_in` is still low at edge A after release, the high count starts anyway. The released phase then lasts A + H − 1 cycles, however long `scl_in` stays low.
- R8: `low_strobe` is 1 for exactly the cycles in which `scl_drive_low` has just changed from 0 to 1. `release_strobe` is 1 in the cycle in which a completed low phase ends. The two strobes are never 1 together.
- R9: Clearing `enable` in the middle of a phase releases SCL on the next edge with no strobe. Setting it again starts a full low phase, with `low_strobe` on the first edge.
- R10: A change of `ccr_val`, `fast_sel` or `duty_sel` during a phase does not change the length of that phase. It applies from the next phase that starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Runs the generator when 1; idle with SCL released when 0 |
| ccr_val | input | 12 | Divider value C in peripheral clock cycles |
| fast_sel | input | 1 | 1 selects fast mode, 0 selects standard mode |
| duty_sel | input | 1 | In fast mode: 1 selects a 16:9 ratio, 0 selects 2:1 |
| rise_lim | input | 6 | Rise allowance in cycles; 0 is treated as 1 |
| scl_in | input | 1 | Synchronised SCL line level |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_strobe | output | 1 | One-cycle pulse when a low phase starts |
| release_strobe | output | 1 | One-cycle pulse when a completed low phase ends |

## Verification
A wrong length from the phase calculator or a miscounting down counter shows as a low or released run of `scl_drive_low` that is too long or too short. The error appears within the first SCL period after enable. A fault in the rise tracking changes only the released run, and only when the bus delay or the rise allowance is greater than one cycle, so the stimulus sweeps both against each other. A sequencer stuck in the wrong state shows on the next edge, as a missing or extra strobe or as SCL not released after `enable` falls.

// File: rtl/scl_gen_pkg.sv
package scl_gen_pkg;

    // Smallest legal divider value in each mode
    localparam int STD_MIN_CCR   = 4;
    localparam int FAST_MIN_CCR  = 1;

    // Fast-mode low/high multipliers
    localparam int FAST_LOW_MUL  = 2;
    localparam int DUTY_LOW_MUL  = 16;
    localparam int DUTY_HIGH_MUL = 9;

    // Extra counter bits needed so that DUTY_LOW_MUL * max divider fits
    localparam int MUL_HEADROOM  = 4;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_RISE,
        PH_HIGH
    } scl_phase_e;

    typedef struct packed {
        logic fast;
        logic duty;
    } scl_mode_t;

endpackage

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
    import scl_gen_pkg::*;
#(
    parameter int CCR_W = 12,
    parameter int CNT_W = CCR_W + MUL_HEADROOM
) (
    input  logic [CCR_W-1:0] ccr,
    input  scl_mode_t        mode,
    output logic [CNT_W-1:0] low_len,
    output logic [CNT_W-1:0] high_len
);

    localparam logic [CCR_W-1:0] STD_FLOOR  = CCR_W'(STD_MIN_CCR);
    localparam logic [CCR_W-1:0] FAST_FLOOR = CCR_W'(FAST_MIN_CCR);

    logic [CCR_W-1:0] floor_v;
    logic [CCR_W-1:0] eff;
    logic [CNT_W-1:0] base;

    always_comb begin
        floor_v = mode.fast ? FAST_FLOOR : STD_FLOOR;
        eff     = (ccr < floor_v) ? floor_v : ccr;
        base    = {{(CNT_W-CCR_W){1'b0}}, eff};
        if (!mode.fast) begin
            low_len  = base;
            high_len = base;
        end else if (!mode.duty) begin
            low_len  = base * CNT_W'(FAST_LOW_MUL);
            high_len = base;
        end else begin
            low_len  = base * CNT_W'(DUTY_LOW_MUL);
            high_len = base * CNT_W'(DUTY_HIGH_MUL);
        end
    end

endmodule

// File: rtl/scl_rise_watch.sv
module scl_rise_watch #(
    parameter int RISE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              active,
    input  logic              scl_in,
    input  logic [RISE_W-1:0] rise_lim,
    output logic              rise_done
);

    logic [RISE_W-1:0] waited;
    logic [RISE_W-1:0] lim_eff;
    logic              expired;

    // A zero allowance is treated as one cycle
    assign lim_eff   = (rise_lim == '0) ? RISE_W'(1) : rise_lim;
    assign expired   = ({1'b0, waited} + (RISE_W+1)'(1)) >= {1'b0, lim_eff};
    assign rise_done = scl_in || expired;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            waited <= '0;
        end else begin
            waited <= waited + RISE_W'(1);
        end
    end

endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
    import scl_gen_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [CNT_W-1:0] low_len,
    input  logic [CNT_W-1:0] high_len,
    input  logic             rise_done,
    output logic             rise_phase,
    output logic             scl_drive_low,
    output logic             low_strobe,
    output logic             release_strobe
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    scl_phase_e       state;
    logic [CNT_W-1:0] remain;

    assign rise_phase = (state == PH_RISE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state          <= PH_IDLE;
            remain         <= '0;
            scl_drive_low  <= 1'b0;
            low_strobe     <= 1'b0;
            release_strobe <= 1'b0;
        end else begin
            low_strobe     <= 1'b0;
            release_strobe <= 1'b0;
            if (!enable) begin
                state         <= PH_IDLE;
                remain        <= '0;
                scl_drive_low <= 1'b0;
            end else begin
                case (state)
                    PH_IDLE: begin
                        state         <= PH_LOW;
                        remain        <= low_len;
                        scl_drive_low <= 1'b1;
                        low_strobe    <= 1'b1;
                    end
                    PH_LOW: begin
                        if (remain <= ONE) begin
                            state          <= PH_RISE;
                            scl_drive_low  <= 1'b0;
                            release_strobe <= 1'b1;
                        end else begin
                            remain <= remain - ONE;
                        end
                    end
                    PH_RISE: begin
                        if (rise_done) begin
                            if (high_len <= ONE) begin
                                state         <= PH_LOW;
                                remain        <= low_len;
                                scl_drive_low <= 1'b1;
                                low_strobe    <= 1'b1;
                            end else begin
                                state  <= PH_HIGH;
                                remain <= high_len - ONE;
                            end
                        end
                    end
                    PH_HIGH: begin
                        if (remain <= ONE) begin
                            state         <= PH_LOW;
                            remain        <= low_len;
                            scl_drive_low <= 1'b1;
                            low_strobe    <= 1'b1;
                        end else begin
                            remain <= remain - ONE;
                        end
                    end
                    default: begin
                        state         <= PH_IDLE;
                        scl_drive_low <= 1'b0;
                    end
                endcase
            end
        end
    end

    // Disabled generator releases SCL and stays silent
    assert_idle_released_R1: assert property (@(posedge clk) disable iff (rst)
        !enable |=> (!scl_drive_low && !low_strobe && !release_strobe));

    // Phase lengths from the calculator are never zero and low never shorter than high
    assert_len_order_R5: assert property (@(posedge clk) disable iff (rst)
        (high_len != '0) && (low_len >= high_len));

    // A counting phase never holds an exhausted counter
    assert_cnt_live_R2: assert property (@(posedge clk) disable iff (rst)
        ((state == PH_LOW) || (state == PH_HIGH)) |-> (remain != '0));

    assert_strobe_excl_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({low_strobe, release_strobe}));

    assert_low_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        low_strobe |-> scl_drive_low);

    assert_rel_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        release_strobe |-> !scl_drive_low);

    assert_drive_rise_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(scl_drive_low) |-> low_strobe);

endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen
    import scl_gen_pkg::*;
#(
    parameter int CCR_W  = 12,
    parameter int RISE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic [CCR_W-1:0]  ccr_val,
    input  logic              fast_sel,
    input  logic              duty_sel,
    input  logic [RISE_W-1:0] rise_lim,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              low_strobe,
    output logic              release_strobe
);

    localparam int CNT_W = CCR_W + MUL_HEADROOM;

    scl_mode_t        mode;
    logic [CNT_W-1:0] low_len;
    logic [CNT_W-1:0] high_len;
    logic             rise_phase;
    logic             rise_done;

    assign mode.fast = fast_sel;
    assign mode.duty = duty_sel;

    scl_phase_calc #(
        .CCR_W (CCR_W),
        .CNT_W (CNT_W)
    ) u_calc (
        .ccr      (ccr_val),
        .mode     (mode),
        .low_len  (low_len),
        .high_len (high_len)
    );

    scl_rise_watch #(
        .RISE_W (RISE_W)
    ) u_rise (
        .clk       (clk),
        .rst       (rst),
        .active    (rise_phase),
        .scl_in    (scl_in),
        .rise_lim  (rise_lim),
        .rise_done (rise_done)
    );

    scl_phase_seq #(
        .CNT_W (CNT_W)
    ) u_seq (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .low_len        (low_len),
        .high_len       (high_len),
        .rise_done      (rise_done),
        .rise_phase     (rise_phase),
        .scl_drive_low  (scl_drive_low),
        .low_strobe     (low_strobe),
        .release_strobe (release_strobe)
    );

endmodule

// File: tb/tb_scl_timing_gen.sv
module tb_scl_timing_gen;

    localparam int CCR_W  = 12;
    localparam int RISE_W = 6;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              enable = 1'b0;
    logic [CCR_W-1:0]  ccr_val = '0;
    logic              fast_sel = 1'b0;
    logic              duty_sel = 1'b0;
    logic [RISE_W-1:0] rise_lim = '0;
    logic              scl_in = 1'b0;
    logic              scl_drive_low;
    logic              low_strobe;
    logic              release_strobe;

    int    checks = 0;
    int    errors = 0;
    int    cycles = 0;
    bit    finished = 1'b0;
    int    bus_delay = 1;
    int    rel_cnt = 0;
    bit    meas_on = 1'b0;
    int    exp_low = 0;
    int    exp_high = 0;
    string tag = "R2";
    int    highs_done = 0;
    bit    prev_d = 1'b0;
    bit    run_v = 1'b0;
    bit    seen_low = 1'b0;
    int    run_n = 0;
    int    seed_dummy;

    scl_timing_gen #(.CCR_W(CCR_W), .RISE_W(RISE_W)) dut (
        .clk            (clk),
        .rst            (rst),
        .enable         (enable),
        .ccr_val        (ccr_val),
        .fast_sel       (fast_sel),
        .duty_sel       (duty_sel),
        .rise_lim       (rise_lim),
        .scl_in         (scl_in),
        .scl_drive_low  (scl_drive_low),
        .low_strobe     (low_strobe),
        .release_strobe (release_strobe)
    );

    always #5 clk = ~clk;

    function automatic int eff_ccr(int c, bit f);
        if (f) return (c < 1) ? 1 : c;
        return (c < 4) ? 4 : c;
    endfunction

    function automatic int low_of(int c, bit f, bit du);
        int e = eff_ccr(c, f);
        if (!f) return e;
        return du ? 16 * e : 2 * e;
    endfunction

    function automatic int high_of(int c, bit f, bit du);
        int e = eff_ccr(c, f);
        return (f && du) ? 9 * e : e;
    endfunction

    function automatic int rel_of(int c, bit f, bit du, int tr, int d);
        int a = (tr == 0) ? 1 : tr;
        int j = (d < a) ? d : a;
        return j + high_of(c, f, du) - 1;
    endfunction

    task automatic chk(string t, int act, int expv, string what);
        checks++;
        if (act != expv) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, expv);
        end
    endtask

    task automatic finish_up();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // Bus model, strobe checks and phase-length measurement
    always @(negedge clk) begin
        if (scl_drive_low) begin
            rel_cnt = 0;
            scl_in  = 1'b0;
        end else begin
            if (rel_cnt < 100000) rel_cnt++;
            scl_in = (rel_cnt >= bus_delay);
        end
        if (!rst) begin
            if (scl_drive_low && !prev_d)
                chk("R8", int'(low_strobe), 1, "low_strobe at drive rise");
            else if (low_strobe)
                chk("R8", 0, 1, "low_strobe without drive rise");
            if (release_strobe && !(!scl_drive_low && prev_d))
                chk("R8", 0, 1, "release_strobe without drive fall");
        end
        prev_d = scl_drive_low;
        if (!meas_on) begin
            run_v    = 1'b0;
            run_n    = 0;
            seen_low = 1'b0;
        end else if (scl_drive_low == run_v) begin
            run_n++;
        end else begin
            if (run_v) begin
                chk(tag, run_n, exp_low, "low phase length");
                chk("R8", int'(release_strobe), 1, "release_strobe at end of low phase");
                seen_low = 1'b1;
            end else if (seen_low) begin
                chk(tag, run_n, exp_high, "released phase length");
                highs_done++;
            end
            run_v = scl_drive_low;
            run_n = 1;
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !finished) begin
            errors++;
            $display("FAIL R1 watchdog actual=%0d expected=%0d", cycles, 150000);
            finish_up();
        end
    end

    task automatic run_cfg(int c, bit f, bit du, int tr, int d, int periods, string t);
        @(negedge clk); #1;
        ccr_val    = CCR_W'(c);
        fast_sel   = f;
        duty_sel   = du;
        rise_lim   = RISE_W'(tr);
        bus_delay  = d;
        exp_low    = low_of(c, f, du);
        exp_high   = rel_of(c, f, du, tr, d);
        tag        = t;
        highs_done = 0;
        meas_on    = 1'b1;
        enable     = 1'b1;
        while (highs_done < periods) @(negedge clk);
        #1;
        enable  = 1'b0;
        meas_on = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        seed_dummy = $urandom(32'h0000_5CA1);
        repeat (4) @(negedge clk);
        #1 rst = 1'b0;

        // R1: idle after reset with enable low
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1", int'({scl_drive_low, low_strobe, release_strobe}), 0, "idle outputs");
        end

        // Directed modes
        run_cfg(10, 1'b0, 1'b0, 9, 1, 3, "R2");
        run_cfg(10, 1'b0, 1'b1, 9, 1, 2, "R2");
        run_cfg(5,  1'b1, 1'b0, 3, 1, 3, "R3");
        run_cfg(2,  1'b1, 1'b1, 3, 1, 3, "R4");

        // R5 clamps
        run_cfg(0,  1'b0, 1'b0, 1, 1, 2, "R5");
        run_cfg(3,  1'b0, 1'b0, 1, 1, 2, "R5");
        run_cfg(0,  1'b1, 1'b0, 1, 1, 3, "R5");
        run_cfg(0,  1'b1, 1'b1, 1, 1, 2, "R5");

        // R6 slow rise within allowance; R7 allowance cap
        run_cfg(6,  1'b0, 1'b0, 9, 4, 3, "R6");
        run_cfg(6,  1'b0, 1'b0, 5, 20, 3, "R7");
        run_cfg(6,  1'b0, 1'b0, 0, 3, 2, "R7");
        run_cfg(1,  1'b1, 1'b0, 2, 6, 2, "R7");

        // Random mix
        for (int i = 0; i < 30; i++) begin
            int  c  = int'($urandom_range(0, 20));
            bit  f  = 1'($urandom_range(0, 1));
            bit  du = 1'($urandom_range(0, 1));
            int  tr = int'($urandom_range(0, 15));
            int  d  = int'($urandom_range(1, 12));
            string t;
            if (d > ((tr == 0) ? 1 : tr)) t = "R7";
            else if (!f) t = "R2";
            else if (!du) t = "R3";
            else t = "R4";
            run_cfg(c, f, du, tr, d, 2, t);
        end

        // R9: disable in the middle of a low phase
        @(negedge clk); #1;
        ccr_val = CCR_W'(8); fast_sel = 1'b0; duty_sel = 1'b0; rise_lim = RISE_W'(9); bus_delay = 2;
        enable = 1'b1;
        repeat (3) @(negedge clk);
        #1 enable = 1'b0;
        @(negedge clk);
        chk("R9", int'({scl_drive_low, low_strobe, release_strobe}), 0, "outputs after disable");
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            chk("R1", int'(scl_drive_low), 0, "released while disabled");
        end
        #1;
        exp_low = 8; exp_high = rel_of(8, 1'b0, 1'b0, 9, 2); tag = "R9";
        highs_done = 0; meas_on = 1'b1; enable = 1'b1;
        @(negedge clk);
        chk("R9", int'({scl_drive_low, low_strobe}), 3, "restart low phase with strobe");
        while (highs_done < 2) @(negedge clk);
        #1 enable = 1'b0; meas_on = 1'b0;
        repeat (3) @(negedge clk);

        // R10: divider change during a low phase
        #1;
        ccr_val = CCR_W'(10); fast_sel = 1'b0; duty_sel = 1'b0; rise_lim = RISE_W'(9); bus_delay = 1;
        exp_low = 10; exp_high = 20; tag = "R10";
        highs_done = 0; meas_on = 1'b1; enable = 1'b1;
        repeat (4) @(negedge clk);
        #1 ccr_val = CCR_W'(20);
        while (highs_done < 1) @(negedge clk);
        #1 exp_low = 20;
        while (highs_done < 2) @(negedge clk);
        #1 enable = 1'b0; meas_on = 1'b0;
        repeat (3) @(negedge clk);

        finish_up();
    end

endmodule